// File: doc/BRIEF.md
# Two-Level Weighted Channel Arbiter

This block decides which of several DMA channels may use a shared data mover next. Every channel presents a request line, a one-bit priority flag and a four-bit weight. The block answers with a one-hot grant. Channels flagged high priority always win over channels flagged low. Among channels of the same level, service is shared in proportion to the weights by means of per-channel credit counters.

A grant stays in place until the granted channel pulses `unit_done`, marking the end of one unit of work. The grant then drops for one cycle. In that cycle a fresh decision is taken and registered, so it becomes visible after the next edge. Weights range from 1 to 15, and a programmed 0 behaves as 1. Ties between equally eligible channels rotate round-robin, starting after the channel granted last.

Top module: `bw_share_arb`

## Requirements
- R1: `ch_grant` has at most one bit set at any time, and it is all zeros while reset is asserted and in the first cycle after reset.
- R2: A grant that appears after an edge where no grant was held goes to a channel whose `ch_req` bit was 1 at that edge.
- R3: When any channel with `ch_hi`=1 is requesting at a decision edge, the grant goes to a channel with `ch_hi`=1. Low-priority channels are granted only when no high-priority channel requests.
- R4: While a grant is held and `unit_done` is 0, the grant does not change. `unit_done` has no effect while no grant is held.
- R5: If `unit_done` is 1 at an edge while a grant is held, `ch_grant` is zero after that edge. The next grant can appear after the following edge.
- R6: Each channel has a credit counter, loaded with its effective weight on a reload. The counter loses one credit per completed unit. When the same channels request continuously within one level, each gets exactly its effective weight in grants per reload period.
- R7: A weight field of 0 acts as weight 1. Weight for channel i sits in `ch_weight[4*i+3:4*i]`.
- R8: At a decision, a requesting channel with zero credit is skipped while any requesting channel of the same level still has credit.
- R9: When every requesting channel at the active level has zero credit, all counters of channels at that level reload from their weights at that decision edge, and the grant is chosen among all requesters at that level.
- R10: Among eligible channels, the first one found in ascending index order after the most recently granted channel wins, wrapping from the last index to 0. After reset, the search starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | N_CH | Per-channel request |
| ch_hi | input | N_CH | Per-channel priority flag, 1 = high level |
| ch_weight | input | 4*N_CH | Per-channel weight, 4 bits each, channel 0 in the low bits |
| unit_done | input | 1 | The granted channel finished one unit of work |
| ch_grant | output | N_CH | One-hot grant, zero when idle |

## Verification
The weighted sharing is tried with all channels requesting at one level with unequal weights, including a zero weight. The grant counts per reload period must equal the effective weights, which separates proportional service from plain round-robin. A two-channel sequence with weights 2 and 1 separates credit skipping from rotation, and a full-exhaustion reload from a partial one. A single high channel against many low ones shows whether strict priority holds. A long stretch of seeded random requests, priorities, weights and done pulses, including done pulses while idle, is compared every cycle against a bench model of the credit and rotation rules.

// File: rtl/bw_arb_pkg.sv
package bw_arb_pkg;

  localparam int unsigned WGT_W = 4;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;

  // weight field of zero behaves as weight one
  function automatic logic [WGT_W-1:0] eff_weight(input logic [WGT_W-1:0] w);
    eff_weight = (w == '0) ? WGT_W'(1) : w;
  endfunction

endpackage

// File: rtl/bw_rr_pick.sv
module bw_rr_pick #(
  parameter int unsigned N_CH = 6,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  cand,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] pick
);

  // scan from the slot after the last winner, wrapping around
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= int'(N_CH); off++) begin
      int idx;
      idx = (int'(last) + off) % int'(N_CH);
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

endmodule

// File: rtl/bw_lvl_sel.sv
module bw_lvl_sel #(
  parameter int unsigned N_CH = 6
) (
  input  logic [N_CH-1:0] req,
  input  logic [N_CH-1:0] hi,
  input  logic [N_CH-1:0] cred_nz,
  output logic [N_CH-1:0] lvl_mask,
  output logic [N_CH-1:0] cand,
  output logic [N_CH-1:0] credited
);

  logic any_hi;

  always_comb begin
    any_hi   = |(req & hi);
    lvl_mask = any_hi ? hi : ~hi;
    cand     = req & lvl_mask;
    credited = cand & cred_nz;
  end

endmodule

// File: rtl/bw_cred_bank.sv
module bw_cred_bank
  import bw_arb_pkg::*;
#(
  parameter int unsigned N_CH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reload_en,
  input  logic [N_CH-1:0]       reload_mask,
  input  logic                  dec_en,
  input  logic [N_CH-1:0]       dec_sel,
  input  logic [N_CH*WGT_W-1:0] weight,
  output logic [N_CH-1:0]       cred_nz
);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [WGT_W-1:0] cred_q;
    logic [WGT_W-1:0] cred_d;
    logic             cred_ce;

    always_comb begin
      cred_d  = cred_q;
      cred_ce = 1'b0;
      if (reload_en && reload_mask[g]) begin
        cred_d  = eff_weight(weight[g*WGT_W +: WGT_W]);
        cred_ce = 1'b1;
      end else if (dec_en && dec_sel[g] && (cred_q != '0)) begin
        cred_d  = cred_q - 1'b1;
        cred_ce = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cred_q <= '0;
      end else if (cred_ce) begin
        cred_q <= cred_d;
      end
    end

    assign cred_nz[g] = (cred_q != '0);

    // a completed unit is always charged to a channel that still holds credit
    p_no_underflow_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && dec_sel[g]) |-> (cred_q != '0));

    // a reload never leaves a zero counter, even for weight field 0
    p_reload_nonzero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (reload_en && reload_mask[g]) |=> (cred_q != '0));
  end

endmodule

// File: rtl/bw_share_arb.sv
module bw_share_arb
  import bw_arb_pkg::*;
#(
  parameter int unsigned N_CH = 6,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       ch_req,
  input  logic [N_CH-1:0]       ch_hi,
  input  logic [N_CH*WGT_W-1:0] ch_weight,
  input  logic                  unit_done,
  output logic [N_CH-1:0]       ch_grant
);

  arb_state_e       state_q, state_d;
  logic [N_CH-1:0]  grant_q, grant_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             last_ce;

  logic [N_CH-1:0]  cred_nz;
  logic [N_CH-1:0]  lvl_mask, cand, credited, pool;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic             reload_en;
  logic             unit_end;

  bw_lvl_sel #(.N_CH(N_CH)) u_lvl (
    .req      (ch_req),
    .hi       (ch_hi),
    .cred_nz  (cred_nz),
    .lvl_mask (lvl_mask),
    .cand     (cand),
    .credited (credited)
  );

  // all requesters at the level exhausted: reload and choose among all of them
  always_comb begin
    reload_en = (state_q == ARB_IDLE) && (cand != '0) && (credited == '0);
    pool      = (credited != '0) ? credited : cand;
    unit_end  = (state_q == ARB_HOLD) && unit_done;
  end

  bw_rr_pick #(.N_CH(N_CH)) u_pick (
    .cand  (pool),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  bw_cred_bank #(.N_CH(N_CH)) u_cred (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload_en   (reload_en),
    .reload_mask (lvl_mask),
    .dec_en      (unit_end),
    .dec_sel     (grant_q),
    .weight      (ch_weight),
    .cred_nz     (cred_nz)
  );

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    last_d  = last_q;
    last_ce = 1'b0;
    case (state_q)
      ARB_IDLE: begin
        if (found) begin
          state_d       = ARB_HOLD;
          grant_d       = '0;
          grant_d[pick] = 1'b1;
          last_d        = pick;
          last_ce       = 1'b1;
        end
      end
      ARB_HOLD: begin
        if (unit_done) begin
          state_d = ARB_IDLE;
          grant_d = '0;
        end
      end
      default: begin
        state_d = ARB_IDLE;
        grant_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDX_W'(N_CH - 1);
    end else if (last_ce) begin
      last_q <= last_d;
    end
  end

  assign ch_grant = grant_q;

  p_onehot_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_grant));

  p_grant_req_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_grant != '0) && ($past(ch_grant) == '0)) |-> (($past(ch_req) & ch_grant) != '0));

  p_hi_first_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_grant != '0) && ($past(ch_grant) == '0) && (($past(ch_req) & $past(ch_hi)) != '0))
      |-> ((ch_grant & $past(ch_hi)) != '0));

  p_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_grant != '0) && !unit_done) |=> $stable(ch_grant));

  p_release_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_grant != '0) && unit_done) |=> (ch_grant == '0));

endmodule

// File: tb/test_bw_share_arb.sv
module test_bw_share_arb;

  localparam int N = 6;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   ch_req;
  logic [N-1:0]   ch_hi;
  logic [N*4-1:0] ch_weight;
  logic           unit_done;
  logic [N-1:0]   ch_grant;

  int checks   = 0;
  int failures = 0;
  bit reported = 0;

  // bench model state
  int           cred_m [N];
  int           last_m;
  logic [N-1:0] gnt_m;

  bw_share_arb #(.N_CH(N)) i_bw_share_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_req    (ch_req),
    .ch_hi     (ch_hi),
    .ch_weight (ch_weight),
    .unit_done (unit_done),
    .ch_grant  (ch_grant)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic int eff_w(input int ch, input logic [N*4-1:0] w);
    int v;
    v = int'(w[ch*4 +: 4]);
    return (v == 0) ? 1 : v;
  endfunction

  // model of R3, R6..R10: decision in idle, charge on done
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cred_m[i] = 0;
      last_m = N - 1;
      gnt_m  = '0;
    end else if (gnt_m != '0) begin
      if (unit_done) begin
        for (int i = 0; i < N; i++)
          if (gnt_m[i] && cred_m[i] > 0) cred_m[i] = cred_m[i] - 1;
        gnt_m = '0;
      end
    end else begin
      logic         anyhi;
      logic [N-1:0] lvl, cnd, crd, pl;
      anyhi = |(ch_req & ch_hi);
      lvl   = anyhi ? ch_hi : ~ch_hi;
      cnd   = ch_req & lvl;
      crd   = '0;
      for (int i = 0; i < N; i++) crd[i] = cnd[i] && (cred_m[i] > 0);
      pl = crd;
      if (cnd != '0 && crd == '0) begin
        for (int i = 0; i < N; i++) if (lvl[i]) cred_m[i] = eff_w(i, ch_weight);
        pl = cnd;
      end
      for (int off = 1; off <= N; off++) begin
        int idx;
        idx = (last_m + off) % N;
        if (gnt_m == '0 && pl[idx]) begin
          gnt_m       = '0;
          gnt_m[idx]  = 1'b1;
          last_m      = idx;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one cycle: wait for negedge, compare grant to model
  task automatic tick();
    @(negedge clk);
    chk(ch_grant === gnt_m, "R10 grant vs model", ch_grant, gnt_m);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ch_req = '0; ch_hi = '0; ch_weight = '0; unit_done = 1'b0;
    repeat (2) @(negedge clk);
    chk(ch_grant === '0, "R1 reset grant", ch_grant, '0);
    rst_n = 1'b1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int cnt [N];
    logic [N-1:0] seq_exp [7];
    logic [N-1:0] g0;

    void'($urandom(32'h5eed_0042));

    // R1: reset and first cycle after reset
    do_reset();
    tick();
    chk(ch_grant === '0, "R1 idle after reset", ch_grant, '0);

    // R6 R7: all low, weights 3,1,2,0,1,1 -> one period is 9 grants
    do_reset();
    ch_weight = {4'd1, 4'd1, 4'd0, 4'd2, 4'd1, 4'd3};
    ch_req = '1;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    for (int c = 0; c < 18; c++) begin
      tick();
      for (int i = 0; i < N; i++) if (ch_grant[i]) cnt[i]++;
      unit_done = (ch_grant != '0);
    end
    chk(cnt[0] == 3, "R6 ch0 share", N'(cnt[0]), N'(3));
    chk(cnt[1] == 1, "R6 ch1 share", N'(cnt[1]), N'(1));
    chk(cnt[2] == 2, "R6 ch2 share", N'(cnt[2]), N'(2));
    chk(cnt[3] == 1, "R7 zero weight share", N'(cnt[3]), N'(1));
    chk(cnt[5] == 1, "R6 ch5 share", N'(cnt[5]), N'(1));

    // R8 R9: ch0 w=2, ch1 w=1 -> 0,1,0,1,0,0,1
    do_reset();
    ch_weight = {16'h0, 4'd0, 4'd0, 4'd1, 4'd2};
    ch_req = 6'b000011;
    seq_exp = '{6'b01, 6'b10, 6'b01, 6'b10, 6'b01, 6'b01, 6'b10};
    for (int k = 0; k < 7; k++) begin
      tick(); // idle decision cycle
      unit_done = 1'b0;
      tick();
      chk(ch_grant === seq_exp[k], (k == 5) ? "R8 skip zero credit" :
          (k == 6) ? "R9 reload" : "R10 rotation", ch_grant, seq_exp[k]);
      unit_done = 1'b1;
    end
    unit_done = 1'b0;

    // R3: ch5 high among low requesters keeps winning
    do_reset();
    ch_weight = '1;
    ch_hi = 6'b100000;
    ch_req = '1;
    for (int k = 0; k < 4; k++) begin
      tick();
      unit_done = 1'b0;
      tick();
      chk(ch_grant === 6'b100000, "R3 high wins", ch_grant, 6'b100000);
      unit_done = 1'b1;
    end
    ch_req = 6'b011111;
    tick();
    unit_done = 1'b0;
    tick();
    chk((ch_grant & 6'b011111) != '0, "R3 low after high leaves", ch_grant, 6'b011111);

    // R4: hold without done; done while idle ignored
    g0 = ch_grant;
    for (int k = 0; k < 5; k++) begin
      ch_req = ~ch_req;
      tick();
      chk(ch_grant === g0, "R4 hold", ch_grant, g0);
    end
    // R5: release next edge, new grant after the following one
    ch_req = '1;
    unit_done = 1'b1;
    tick();
    chk(ch_grant === '0, "R5 release", ch_grant, '0);
    unit_done = 1'b0;
    tick();
    chk(ch_grant != '0, "R5 next decision", ch_grant, gnt_m);
    unit_done = 1'b1;
    tick();
    ch_req = '0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(ch_grant === '0, "R4 done while idle", ch_grant, '0);
    end
    unit_done = 1'b0;

    // random phase, checked each cycle against the model (R2 R3 R6 R8 R9 R10)
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      tick();
      ch_req = N'($urandom);
      if ($urandom % 16 == 0) ch_hi = N'($urandom);
      if ($urandom % 32 == 0) ch_weight = (N*4)'({$urandom, $urandom});
      unit_done = ($urandom % 3 == 0);
    end

    report();
    $finish;
  end

endmodule